// File: doc/BRIEF.md
# Dual-Bank Clock Divider

This block turns one input clock into two banks of divided clocks. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter, one fifth or one sixth of it. Every output has a 50% duty cycle, and that includes the divide-by-5 ratio. Both banks are built from counters that advance on the same enabled input edge, so any edges the two banks have in common fall at the same instant.

A single active-low run control starts and stops both banks together. It is captured on the falling edge of the input clock, so the dividers can only be started or stopped while the clock is low, and a shortened pulse can never reach them. An asynchronous active-low master reset forces every true output low and every counter to zero. This places all banks in phase for the first counted rising edge after release. Each output bank is replicated for fan-out and also provides complementary copies.

Top module: `dual_bank_clkdiv`

## Requirements
- R1: With `a_sel` = 0, every `a_clk` bit has a period of 2 input cycles and stays high for 1 of them.
- R2: With `a_sel` = 1, every `a_clk` bit has a period of 4 input cycles and stays high for 2 of them.
- R3: With `b_sel` = 2'b00, every `b_clk` bit has a period of 4 input cycles and stays high for 2 of them.
- R4: With `b_sel` = 2'b01, every `b_clk` bit has a period of 6 input cycles and stays high for 3 of them.
- R5: With `b_sel` = 2'b10 or 2'b11, every `b_clk` bit has a period of 5 input cycles and stays high for 5 input half-periods. It rises on an input rising edge and falls on an input falling edge.
- R6: While `run_n` is high (as captured per R7), no output changes. Once the dividers are re-enabled, they continue from the exact state at which they stopped.
- R7: `run_n` is captured on each falling edge of `clk_in`. A rising edge advances the dividers only if `run_n` was low at the falling edge just before it. A change of `run_n` while the clock is low therefore has no effect on the next rising edge.
- R8: While `rst_n` is low, every `a_clk`/`b_clk` bit is low and every complementary bit is high. This takes effect without waiting for a clock edge.
- R9: After `rst_n` is released, every true output rises on the first counted rising edge, so all banks start in phase.
- R10: `a_clk_n` and `b_clk_n` are always the bitwise inverse of `a_clk` and `b_clk`.
- R11: Select inputs are sampled only at the start of each output period. A change in mid-period lets the current period finish at the old ratio, and the new ratio starts with the next period.
- R12: All bits within one bank carry the same waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low master reset |
| run_n | input | 1 | Active-low run control, captured on the falling edge |
| a_sel | input | 1 | Bank A ratio: 0 = /2, 1 = /4 |
| b_sel | input | 2 | Bank B ratio: 00 = /4, 01 = /6, 1x = /5 |
| a_clk | output | NUM_A | Bank A divided clocks |
| a_clk_n | output | NUM_A | Bank A complementary clocks |
| b_clk | output | NUM_B | Bank B divided clocks |
| b_clk_n | output | NUM_B | Bank B complementary clocks |

## Verification
On every cycle, the assertions check four things:
- Each counter stays below the ratio it is running.
- A stopped divider keeps its count and its output level.
- The half-cycle extension flop is set only under an odd ratio.
- The outputs stay low throughout reset.

Some behaviours only the bench scenarios can show, because each of them depends on a waveform seen across many edges:
- The exact period and high time of each ratio, measured in half-periods.
- The in-phase start after reset.
- The one-edge lag caused by the falling-edge capture of `run_n`.
- The deferral of a select change to the next period boundary.

// File: rtl/cdiv_pkg.sv
`timescale 1ns/1ps
package cdiv_pkg;
  localparam int MAX_RATIO = 6;
  localparam int RATIO_W   = $clog2(MAX_RATIO + 1);
  typedef logic [RATIO_W-1:0] ratio_t;

  localparam ratio_t A_FAST   = ratio_t'(2);
  localparam ratio_t A_SLOW   = ratio_t'(4);
  localparam ratio_t B_QUART  = ratio_t'(4);
  localparam ratio_t B_SIXTH  = ratio_t'(6);
  localparam ratio_t B_FIFTH  = ratio_t'(5);

  function automatic ratio_t bank_a_ratio(input logic sel);
    return sel ? A_SLOW : A_FAST;
  endfunction

  function automatic ratio_t bank_b_ratio(input logic [1:0] sel);
    ratio_t r;
    case (sel)
      2'b00:   r = B_QUART;
      2'b01:   r = B_SIXTH;
      default: r = B_FIFTH;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/cdiv_enable_sync.sv
`timescale 1ns/1ps
module cdiv_enable_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic run_n,
  output logic run
);
  logic run_d;

  always_comb begin
    run_d = ~run_n;
  end

  // Captured on the falling edge so the enable only moves while clk is low.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) run <= 1'b0;
    else        run <= run_d;
  end
endmodule

// File: rtl/cdiv_core.sv
`timescale 1ns/1ps
module cdiv_core #(
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio_in,
  output logic               clk_out
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt_q, cnt_d;
  logic [RATIO_W-1:0] ratio_q, ratio_d, ratio_eff, high_lim;
  logic               base_q, base_d;
  logic               half_q, half_d;

  // Next-state: ratio is taken from the input only at the period start.
  always_comb begin
    ratio_eff = (cnt_q == '0) ? ratio_in : ratio_q;
    high_lim  = ratio_eff >> 1;
    ratio_d   = ratio_eff;
    cnt_d     = (cnt_q == ratio_eff - ONE) ? '0 : cnt_q + ONE;
    base_d    = (cnt_d != '0) && (cnt_d <= high_lim);
    half_d    = base_q & ratio_q[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      ratio_q <= '0;
      base_q  <= 1'b0;
    end else if (run) begin
      cnt_q   <= cnt_d;
      ratio_q <= ratio_d;
      base_q  <= base_d;
    end
  end

  // Half-period extension for odd ratios; enable seen is the pre-edge value.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)   half_q <= 1'b0;
    else if (run) half_q <= half_d;
  end

  assign clk_out = base_q | half_q;

  // R11: counter never reaches the active ratio
  a_r11_count_below_ratio: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (cnt_q < ratio_q));

  // R6: an uncounted edge leaves count and output level untouched
  a_r6_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(cnt_q) && $stable(base_q)));

  // R5: the half-period extension only exists under an odd ratio
  a_r5_half_odd_only: assert property (@(negedge clk) disable iff (!rst_n)
    half_q |-> ratio_q[0]);

  // R8: output held low while reset is applied
  a_r8_reset_low: assert property (@(posedge clk)
    !rst_n |-> !clk_out);
endmodule

// File: rtl/dual_bank_clkdiv.sv
`timescale 1ns/1ps
module dual_bank_clkdiv #(
  parameter int NUM_A = 2,
  parameter int NUM_B = 2
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             run_n,
  input  logic             a_sel,
  input  logic [1:0]       b_sel,
  output logic [NUM_A-1:0] a_clk,
  output logic [NUM_A-1:0] a_clk_n,
  output logic [NUM_B-1:0] b_clk,
  output logic [NUM_B-1:0] b_clk_n
);
  import cdiv_pkg::*;

  logic   run;
  ratio_t ratio_a, ratio_b;
  logic   div_a, div_b;

  always_comb begin
    ratio_a = bank_a_ratio(a_sel);
    ratio_b = bank_b_ratio(b_sel);
  end

  cdiv_enable_sync i_en (
    .clk   (clk_in),
    .rst_n (rst_n),
    .run_n (run_n),
    .run   (run)
  );

  cdiv_core #(.RATIO_W(RATIO_W)) i_bank_a (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .run      (run),
    .ratio_in (ratio_a),
    .clk_out  (div_a)
  );

  cdiv_core #(.RATIO_W(RATIO_W)) i_bank_b (
    .clk      (clk_in),
    .rst_n    (rst_n),
    .run      (run),
    .ratio_in (ratio_b),
    .clk_out  (div_b)
  );

  for (genvar i = 0; i < NUM_A; i++) begin : g_a_out
    assign a_clk[i]   = div_a;
    assign a_clk_n[i] = ~div_a;
  end

  for (genvar i = 0; i < NUM_B; i++) begin : g_b_out
    assign b_clk[i]   = div_b;
    assign b_clk_n[i] = ~div_b;
  end
endmodule

// File: tb/test_dual_bank_clkdiv.sv
`timescale 1ns/1ps
module test_dual_bank_clkdiv;
  localparam int NUM_A = 2;
  localparam int NUM_B = 2;

  logic clk = 1'b0;
  logic rst_n, run_n, a_sel;
  logic [1:0] b_sel;
  logic [NUM_A-1:0] a_clk, a_clk_n;
  logic [NUM_B-1:0] b_clk, b_clk_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dual_bank_clkdiv #(.NUM_A(NUM_A), .NUM_B(NUM_B)) i_dual_bank_clkdiv (
    .clk_in (clk), .rst_n (rst_n), .run_n (run_n), .a_sel (a_sel), .b_sel (b_sel),
    .a_clk (a_clk), .a_clk_n (a_clk_n), .b_clk (b_clk), .b_clk_n (b_clk_n)
  );

  // {a_sel, b_sel}
  localparam logic [2:0] VEC [6] = '{3'b0_00, 3'b1_01, 3'b0_10, 3'b1_11, 3'b1_00, 3'b0_01};

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic bit mdl(input int j, input int n);
    return (j % (2 * n)) < n;
  endfunction

  function automatic int ratio_a_of(input logic s);
    return s ? 4 : 2;
  endfunction

  function automatic int ratio_b_of(input logic [1:0] s);
    return (s == 2'b00) ? 4 : ((s == 2'b01) ? 6 : 5);
  endfunction

  task automatic half(input bit hi);
    if (hi) @(posedge clk); else @(negedge clk);
    #5;
  endtask

  task automatic cmp_banks(input bit ea, input bit eb, input string ta, input string tb);
    logic [NUM_A-1:0] xa;
    logic [NUM_B-1:0] xb;
    xa = ea ? '1 : '0;
    xb = eb ? '1 : '0;
    check(a_clk == xa && a_clk_n == ~xa, ta, {a_clk_n, a_clk}, {~xa, xa});
    check(b_clk == xb && b_clk_n == ~xb, tb, {b_clk_n, b_clk}, {~xb, xb});
  endtask

  task automatic do_reset();
    @(posedge clk); #5;
    rst_n = 1'b0;
    #1;
    // R8: reset acts without a clock edge
    check(a_clk == '0 && b_clk == '0, "R8", {a_clk, b_clk}, 0);
    @(negedge clk); #5;
    check(a_clk == '0 && b_clk == '0 && a_clk_n == '1 && b_clk_n == '1, "R8",
          {a_clk_n, b_clk_n, a_clk, b_clk}, {{NUM_A{1'b1}}, {NUM_B{1'b1}}, {NUM_A{1'b0}}, {NUM_B{1'b0}}});
    @(posedge clk); #5;
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; run_n = 1'b0; a_sel = 1'b0; b_sel = 2'b00;
    #25;

    // Table walk: ratio and duty for each select pair
    for (int v = 0; v < 6; v++) begin
      int na, nb;
      string ta, tb;
      a_sel = VEC[v][2];
      b_sel = VEC[v][1:0];
      na = ratio_a_of(a_sel);
      nb = ratio_b_of(b_sel);
      ta = a_sel ? "R2" : "R1";
      tb = (b_sel == 2'b00) ? "R3" : ((b_sel == 2'b01) ? "R4" : "R5");
      do_reset();
      for (int j = 0; j < 24; j++) begin
        half(j % 2 == 0);
        if (j == 0) cmp_banks(1'b1, 1'b1, "R9", "R9");
        else        cmp_banks(mdl(j, na), mdl(j, nb), ta, tb);
      end
      check(a_clk_n == ~a_clk && b_clk_n == ~b_clk, "R10", {a_clk_n, b_clk_n}, {~a_clk, ~b_clk});
      check((a_clk == '0 || a_clk == '1) && (b_clk == '0 || b_clk == '1), "R12", {a_clk, b_clk}, 0);
    end

    // Hold and resume: /4 and /5, stopped while both outputs are high
    a_sel = 1'b1; b_sel = 2'b10;
    do_reset();
    for (int j = 0; j < 3; j++) begin
      half(j % 2 == 0);
      cmp_banks(mdl(j, 4), mdl(j, 5), "R6", "R6");
    end
    run_n = 1'b1;                          // set while clk high
    half(1'b0);                            // this falling edge still clocks the extension flop
    cmp_banks(mdl(3, 4), mdl(3, 5), "R6", "R6");
    for (int k = 0; k < 8; k++) begin
      half(k % 2 == 0);
      cmp_banks(mdl(3, 4), mdl(3, 5), "R6", "R6");
    end
    run_n = 1'b0;                          // set while clk low: next rising edge must not count
    half(1'b1);
    cmp_banks(mdl(3, 4), mdl(3, 5), "R7", "R7");
    half(1'b0);
    cmp_banks(mdl(3, 4), mdl(3, 5), "R7", "R7");
    for (int j = 4; j < 24; j++) begin
      half(j % 2 == 0);
      cmp_banks(mdl(j, 4), mdl(j, 5), "R6", "R6");
    end

    // Select change in mid-period
    a_sel = 1'b0; b_sel = 2'b01;
    do_reset();
    for (int j = 0; j < 28; j++) begin
      half(j % 2 == 0);
      cmp_banks((j < 4) ? mdl(j, 2) : mdl(j - 4, 4),
                (j < 12) ? mdl(j, 6) : mdl(j - 12, 4), "R11", "R11");
      if (j == 2) begin
        a_sel = 1'b1;
        b_sel = 2'b00;
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule